// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block controls 29 general-purpose pins arranged as four 8-bit ports, where the top port has only five pins. Software reaches the pins through two register paths. The first is a 16-byte runtime window. It holds a data-out and a data-in register for every port, and edge-event enable and status registers for the two lowest ports. The runtime registers of each port sit next to each other in the window.

The second path is indirect and sets the electrical mode of each pin. Software first writes a pin pointer that encodes a port number and a bit index. It then reads or writes a small configuration byte for that one pin. The byte holds the pin's drive enable, the choice between push-pull and open-drain, and the pull-up enable.

The block drives four pad control vectors: output value, output enable, push-pull select and pull-up enable. It samples the pad levels on a separate input vector.

Top module: `gpio_bank_ctl`

## Requirements
- R1: While reset is asserted and right after it, `pad_oe`, `pad_out`, `pad_pp` and `pad_pu` are all zero, and every data-out register reads 0.
- R2: The data-out registers sit at runtime offsets 0x0 (port 0), 0x4 (port 1), 0x8 (port 2) and 0xA (port 3). A write takes effect at the clock edge, and a read returns the stored value on `rt_rdata` in the same cycle.
- R3: In port 3, data-out bits 7..5 belong to no pin. They always read 0, and writes to them have no effect.
- R4: The data-in registers sit at offsets 0x1, 0x5, 0x9 and 0xB. A read returns the current `pad_in` levels of that port, with bit b of port p coming from pin 8p+b. Port 3 bits 7..5 read 0.
- R5: The pin pointer is written with `cf_addr`=0. Bits 6..4 hold the port and bits 2..0 hold the bit index, which selects pin 8*port+bit. Reading the pointer back returns it with bits 7 and 3 forced to 0.
- R6: The pin configuration byte is accessed with `cf_addr`=1. Bit 0 is drive enable, bit 1 is push-pull (0 means open-drain) and bit 2 is pull-up. It reads as {5'b0, pull-up, push-pull, enable} for the selected pin. A write changes only the selected pin, and `pad_pp`/`pad_pu` show bits 1 and 2 of each pin.
- R7: A pin whose enable bit is 0 has `pad_oe` low whatever its data-out bit is, so it stays tristated and acts as an input.
- R8: An enabled open-drain pin always has `pad_out` 0. Its `pad_oe` is high only while its data-out bit is 0. An enabled push-pull pin has `pad_oe` high and `pad_out` equal to its data-out bit.
- R9: Pins 0..15 have event enable registers at 0x2 and 0x6 and event status registers at 0x3 and 0x7. A status bit is set by a rising or falling edge of its pad, but only while its enable bit is 1. An edge on a disabled pin sets nothing.
- R10: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. If an edge on an enabled pin occurs in the same cycle as the clear, the bit stays set.
- R11: Offsets 0xC..0xF read 0 and ignore writes. A pointer that names no existing pin (port above 3, or pin 29 and up) makes the configuration byte read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_wr | input | 1 | Runtime register write strobe |
| rt_addr | input | 4 | Runtime register offset |
| rt_wdata | input | 8 | Runtime write data |
| rt_rdata | output | 8 | Runtime read data (combinational) |
| cf_wr | input | 1 | Configuration path write strobe |
| cf_addr | input | 1 | 0 = pin pointer, 1 = pin configuration byte |
| cf_wdata | input | 8 | Configuration write data |
| cf_rdata | output | 8 | Configuration read data (combinational) |
| pad_in | input | 29 | Pad levels |
| pad_out | output | 29 | Pad output value |
| pad_oe | output | 29 | Pad output enable |
| pad_pp | output | 29 | Pad push-pull select (0 = open-drain) |
| pad_pu | output | 29 | Pad pull-up enable |

## Verification
The bench first targets the three unused bits of port 3. A design that stored those bits would read back 0xFF instead of 0x1F.

It points the pin pointer at nonexistent pins and at the unmapped offsets. A design that decoded these loosely would alias them onto real pins, and a configuration write would then appear on a real pad.

In open-drain mode it checks that a data-out value of 1 releases the pad. A design that drove the level instead would push a 1 onto the pad.

For the event logic it checks three cases:
- An edge on a pin whose enable bit is clear must leave the status bit at 0.
- A write of 0 to a status bit must not clear it.
- When an edge and a write-1 clear arrive in the same cycle, the edge must win. A design that ordered these the other way would lose that event.

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl #(
  parameter int NPINS    = 29,
  parameter int EV_PORTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rt_wr,
  input  logic [3:0]       rt_addr,
  input  logic [7:0]       rt_wdata,
  output logic [7:0]       rt_rdata,
  input  logic             cf_wr,
  input  logic             cf_addr,
  input  logic [7:0]       cf_wdata,
  output logic [7:0]       cf_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pp,
  output logic [NPINS-1:0] pad_pu
);
  localparam int NPORTS = (NPINS + 7) / 8;
  localparam int NPAD   = NPORTS * 8;
  localparam int EVB    = EV_PORTS * 8;

  // k: 0 data-out, 1 data-in, 2 event enable, 3 event status
  function automatic logic [3:0] reg_off(input int p, input int k);
    if (p < EV_PORTS) return 4'(4 * p + k);
    return 4'(4 * EV_PORTS + 2 * (p - EV_PORTS) + k);
  endfunction

  logic [NPINS-1:0] dout_q, oe_q, pp_q, pu_q;
  logic [EVB-1:0]   ev_en_q, ev_st_q, pin_prev_q;
  logic [7:0]       sel_q;
  logic [5:0]       sel_idx;
  logic [NPAD-1:0]  dout_pad, din_pad;
  logic [63:0]      oe_x, pp_x, pu_x;

  assign sel_idx  = {sel_q[6:4], sel_q[2:0]};
  assign dout_pad = NPAD'(dout_q);
  assign din_pad  = NPAD'(pad_in);
  assign oe_x     = 64'(oe_q);
  assign pp_x     = 64'(pp_q);
  assign pu_x     = 64'(pu_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q     <= '0;
      oe_q       <= '0;
      pp_q       <= '0;
      pu_q       <= '0;
      ev_en_q    <= '0;
      ev_st_q    <= '0;
      pin_prev_q <= '0;
      sel_q      <= '0;
    end else begin
      pin_prev_q <= pad_in[EVB-1:0];
      if (cf_wr && !cf_addr) sel_q <= cf_wdata & 8'h77;
      for (int i = 0; i < NPINS; i++) begin
        if (rt_wr && rt_addr == reg_off(i / 8, 0)) dout_q[i] <= rt_wdata[i % 8];
        if (cf_wr && cf_addr && sel_idx == 6'(i)) begin
          oe_q[i] <= cf_wdata[0];
          pp_q[i] <= cf_wdata[1];
          pu_q[i] <= cf_wdata[2];
        end
      end
      for (int i = 0; i < EVB; i++) begin
        if (rt_wr && rt_addr == reg_off(i / 8, 2)) ev_en_q[i] <= rt_wdata[i % 8];
        ev_st_q[i] <= (ev_st_q[i] & ~(rt_wr && rt_addr == reg_off(i / 8, 3) && rt_wdata[i % 8]))
                    | (ev_en_q[i] & (pad_in[i] ^ pin_prev_q[i]));
      end
    end
  end

  always_comb begin
    rt_rdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (rt_addr == reg_off(p, 0)) rt_rdata = dout_pad[p*8 +: 8];
      if (rt_addr == reg_off(p, 1)) rt_rdata = din_pad[p*8 +: 8];
    end
    for (int p = 0; p < EV_PORTS; p++) begin
      if (rt_addr == reg_off(p, 2)) rt_rdata = ev_en_q[p*8 +: 8];
      if (rt_addr == reg_off(p, 3)) rt_rdata = ev_st_q[p*8 +: 8];
    end
  end

  assign cf_rdata = cf_addr ? {5'b0, pu_x[sel_idx], pp_x[sel_idx], oe_x[sel_idx]} : sel_q;

  assign pad_out = pp_q & dout_q;
  assign pad_oe  = oe_q & (pp_q | ~dout_q);
  assign pad_pp  = pp_q;
  assign pad_pu  = pu_q;
endmodule

module gpio_bank_ctl_chk #(
  parameter int NPINS    = 29,
  parameter int EV_PORTS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rt_wr,
  input logic [3:0]       rt_addr,
  input logic [7:0]       rt_wdata,
  input logic [7:0]       rt_rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pp,
  input logic [NPINS-1:0] pad_pu,
  input logic [NPINS-1:0] dout_q,
  input logic [EV_PORTS*8-1:0] ev_en_q,
  input logic [EV_PORTS*8-1:0] ev_st_q
);
  localparam int NPORTS  = (NPINS + 7) / 8;
  localparam int TOPN    = NPINS - 8 * (NPORTS - 1);
  localparam logic [7:0] TOP_MASK = 8'((1 << TOPN) - 1);
  localparam logic [3:0] TOP_OFF  = 4'(4 * EV_PORTS + 2 * (NPORTS - 1 - EV_PORTS));
  localparam logic [4:0] MAP_END  = 5'(4 * EV_PORTS + 2 * (NPORTS - EV_PORTS));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_pp == '0 && pad_pu == '0));

  assert_dout_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_wr && rt_addr == 4'h0) |=> (dout_q[7:0] == $past(rt_wdata)));

  assert_top_port_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_addr == TOP_OFF) |-> ((rt_rdata & ~TOP_MASK) == 8'h00));

  assert_event_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_st_q & ~$past(ev_st_q) & ~$past(ev_en_q)) == '0));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rt_addr} >= MAP_END) |-> (rt_rdata == 8'h00));
endmodule

bind gpio_bank_ctl gpio_bank_ctl_chk #(.NPINS(NPINS), .EV_PORTS(EV_PORTS)) i_chk (.*);

// File: tb/test_gpio_bank_ctl.sv
module test_gpio_bank_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rt_wr = 1'b0;
  logic [3:0]  rt_addr = '0;
  logic [7:0]  rt_wdata = '0;
  logic [7:0]  rt_rdata;
  logic        cf_wr = 1'b0;
  logic        cf_addr = 1'b0;
  logic [7:0]  cf_wdata = '0;
  logic [7:0]  cf_rdata;
  logic [28:0] pad_in = '0;
  logic [28:0] pad_out, pad_oe, pad_pp, pad_pu;

  int n_chk = 0;
  int n_err = 0;

  gpio_bank_ctl i_gpio_bank_ctl (
    .clk(clk), .rst_n(rst_n),
    .rt_wr(rt_wr), .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata),
    .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pp(pad_pp), .pad_pu(pad_pu)
  );

  always #5 clk = ~clk;

  // entry: op[31:28] (0 rt write, 1 rt check, 2 cf write, 3 cf check), addr[27:24],
  // data[23:16], expected[15:8], requirement number[7:0]
  localparam int NV = 24;
  localparam logic [31:0] VEC [NV] = '{
    {4'd0, 4'h0, 8'hA5, 8'h00, 8'd2},  // R2 port 0 data-out
    {4'd1, 4'h0, 8'h00, 8'hA5, 8'd2},
    {4'd0, 4'h4, 8'h3C, 8'h00, 8'd2},  // R2 port 1
    {4'd1, 4'h4, 8'h00, 8'h3C, 8'd2},
    {4'd0, 4'h8, 8'hFF, 8'h00, 8'd2},  // R2 port 2
    {4'd1, 4'h8, 8'h00, 8'hFF, 8'd2},
    {4'd0, 4'hA, 8'hFF, 8'h00, 8'd3},  // R3 port 3 masked
    {4'd1, 4'hA, 8'h00, 8'h1F, 8'd3},
    {4'd0, 4'hC, 8'h55, 8'h00, 8'd11}, // R11 unmapped
    {4'd1, 4'hC, 8'h00, 8'h00, 8'd11},
    {4'd1, 4'hF, 8'h00, 8'h00, 8'd11},
    {4'd2, 4'h0, 8'hFF, 8'h00, 8'd5},  // R5 pointer masking
    {4'd3, 4'h0, 8'h00, 8'h77, 8'd5},
    {4'd2, 4'h1, 8'h07, 8'h00, 8'd11}, // R11 port 7 absent
    {4'd3, 4'h1, 8'h00, 8'h00, 8'd11},
    {4'd2, 4'h0, 8'h12, 8'h00, 8'd6},  // R6 pin 10
    {4'd2, 4'h1, 8'hFF, 8'h00, 8'd6},
    {4'd3, 4'h1, 8'h00, 8'h07, 8'd6},
    {4'd2, 4'h0, 8'h13, 8'h00, 8'd6},  // R6 pin 11 untouched
    {4'd3, 4'h1, 8'h00, 8'h00, 8'd6},
    {4'd2, 4'h0, 8'h35, 8'h00, 8'd11}, // R11 pin 29 absent
    {4'd2, 4'h1, 8'h07, 8'h00, 8'd11},
    {4'd3, 4'h1, 8'h00, 8'h00, 8'd11},
    {4'd2, 4'h0, 8'h34, 8'h00, 8'd6}   // R6 select pin 28
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rtw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    rt_wr = 1'b1; rt_addr = a; rt_wdata = d;
    @(negedge clk);
    rt_wr = 1'b0;
  endtask

  task automatic cfw(input logic a, input logic [7:0] d);
    @(negedge clk);
    cf_wr = 1'b1; cf_addr = a; cf_wdata = d;
    @(negedge clk);
    cf_wr = 1'b0;
  endtask

  task automatic rtc(input string tag, input logic [3:0] a, input logic [7:0] e);
    rt_addr = a;
    #1;
    chk(tag, 32'(rt_rdata), 32'(e));
  endtask

  task automatic cfc(input string tag, input logic a, input logic [7:0] e);
    cf_addr = a;
    #1;
    chk(tag, 32'(cf_rdata), 32'(e));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pad_oe in reset", 32'(pad_oe), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pad_oe", 32'(pad_oe), 32'd0);
    chk("R1 pad_out", 32'(pad_out), 32'd0);
    chk("R1 pad_pu", 32'(pad_pu), 32'd0);
    chk("R1 pad_pp", 32'(pad_pp), 32'd0);
    rtc("R1 dout0", 4'h0, 8'h00);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][31:28])
        4'd0: rtw(VEC[v][27:24], VEC[v][23:16]);
        4'd1: rtc($sformatf("R%0d vec %0d", VEC[v][7:0], v), VEC[v][27:24], VEC[v][15:8]);
        4'd2: cfw(VEC[v][24], VEC[v][23:16]);
        default: cfc($sformatf("R%0d vec %0d", VEC[v][7:0], v), VEC[v][24], VEC[v][15:8]);
      endcase
    end

    // pin 28: push-pull, enabled; dout port3 bit4 = 1
    cfw(1'b1, 8'h03);
    cfc("R6 pin28 cfg", 1'b1, 8'h03);
    chk("R8 pin28 push-pull out", 32'(pad_out[28]), 32'd1);
    chk("R8 pin28 push-pull oe", 32'(pad_oe[28]), 32'd1);
    chk("R6 pin28 pull-up off", 32'(pad_pu[28]), 32'd0);

    // pin 10 currently 0x07 with dout bit = 1
    chk("R6 pin10 pu", 32'(pad_pu[10]), 32'd1);
    chk("R2 pin10 out", 32'(pad_out[10]), 32'd1);
    chk("R6 pin11 pp untouched", 32'(pad_pp[11]), 32'd0);

    // open-drain on pin 10
    cfw(1'b0, 8'h12);
    cfw(1'b1, 8'h01);
    chk("R8 od release oe", 32'(pad_oe[10]), 32'd0);
    chk("R8 od release out", 32'(pad_out[10]), 32'd0);
    rtw(4'h4, 8'h38);
    chk("R8 od drive-low oe", 32'(pad_oe[10]), 32'd1);
    chk("R8 od drive-low out", 32'(pad_out[10]), 32'd0);

    // tristate with push-pull selected
    cfw(1'b1, 8'h02);
    rtw(4'h4, 8'h3C);
    chk("R7 tristate oe", 32'(pad_oe[10]), 32'd0);
    chk("R6 pp visible", 32'(pad_pp[10]), 32'd1);
    rtw(4'h4, 8'h38);
    chk("R7 tristate oe low data", 32'(pad_oe[10]), 32'd0);

    // data-in
    @(negedge clk);
    pad_in = 29'h1ABCDEF0;
    rtc("R4 din port0", 4'h1, 8'hF0);
    rtc("R4 din port1", 4'h5, 8'hDE);
    rtc("R4 din port2", 4'h9, 8'hBC);
    rtc("R4 din port3", 4'hB, 8'h1A);

    // events
    @(negedge clk);
    rtc("R9 disabled edges", 4'h3, 8'h00);
    rtc("R9 disabled edges port1", 4'h7, 8'h00);
    rtw(4'h2, 8'h01);
    rtw(4'h6, 8'h80);
    rtc("R9 enable readback", 4'h2, 8'h01);
    pad_in[0] = 1'b1;
    @(negedge clk);
    rtc("R9 rising edge", 4'h3, 8'h01);
    pad_in[1] = 1'b1;
    @(negedge clk);
    rtc("R9 disabled pin", 4'h3, 8'h01);
    pad_in[15] = 1'b0;
    @(negedge clk);
    rtc("R9 falling edge", 4'h7, 8'h80);
    rtw(4'h3, 8'h00);
    rtc("R10 write zero keeps", 4'h3, 8'h01);
    rtw(4'h3, 8'h01);
    rtc("R10 write one clears", 4'h3, 8'h00);
    @(negedge clk);
    rt_wr = 1'b1; rt_addr = 4'h7; rt_wdata = 8'h80;
    pad_in[15] = 1'b1;
    @(negedge clk);
    rt_wr = 1'b0;
    rtc("R10 edge beats clear", 4'h7, 8'h80);
    rtw(4'h7, 8'h80);
    rtc("R10 cleared", 4'h7, 8'h00);

    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset pad_oe", 32'(pad_oe), 32'd0);
    chk("R1 reset pad_pp", 32'(pad_pp), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rtc("R1 reset dout3", 4'hA, 8'h00);
    cfc("R1 reset pointer", 1'b0, 8'h00);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule